// File: doc/BRIEF.md
# Vector Accelerator Exception Capture Unit

This block gathers fault reports from a vector accelerator into a single pending exception, kept as a cause code plus one auxiliary data word, and drives an interrupt line toward the host core. Fault requests come from external paths (configuration, decode, thread fetch and memory), each carrying a cause code and an aux word. The unit also checks the thread-fetch program counter for misalignment itself.

The unit also decodes host command words. Two privileged commands read the pending cause and aux back. Reading the cause acknowledges the interrupt. A privileged kill command stops every active thread below the current vector length. A launch input starts those threads. Save and restore commands are only privilege-checked.

The meaning of the aux word depends on the cause code. For cause 0 it selects the offending configuration field (0 = integer register count, 1 = float register count). For causes 1 to 3 it is the instruction word. For causes 4 to 7 it is the thread-fetch program counter. For causes 8 to 11 it is the faulting virtual address.

Top module: `vxcpt_unit`

## Requirements
- R1: After reset the cause and aux registers are both zero, irq is low, rd_valid and priv_fault are low, and every run flag is clear.
- R2: A fault request that is captured writes its cause code and aux word into the registers, and irq is high from the next clock edge onward.
- R3: Read-cause returns the cause, zero-extended, on rd_data with rd_valid one cycle after the command, and clears irq. Read-aux returns the aux word the same way and leaves irq and the registers unchanged.
- R4: Read-cause, read-aux, kill, save and restore issued with sup_mode low have no effect of their own and produce no read response. They raise cause 2 with the command word as aux, and priv_fault pulses high for one cycle after the command.
- R5: A command whose bits [6:0] are not 0x0B, 0x2B, 0x5B or 0x7B is ignored: no fault, no read response and no change to the run flags.
- R6: An accepted command word that matches no known command raises cause 1 with the command word as aux.
- R7: The command encodings are as follows. Read-cause is (word & 0xFFFFF07F) == 0x0000402B. Read-aux is (word & 0xFFFFF07F) == 0x0200402B. Kill is word == 0x0400302B exactly. Save is (word & 0xFFF07FFF) == 0x0000302B. Restore is (word & 0xFFF07FFF) == 0x0200302B.
- R8: When tf_valid is high and tf_pc[1:0] is nonzero, cause 4 is raised with tf_pc as aux. An aligned tf_pc raises nothing.
- R9: An accepted kill in supervisor mode clears the run flag of every thread whose index is below vlen. Launch sets those same flags. Kill wins over launch.
- R10: While an exception is pending (irq high), new fault requests are dropped, and cause and aux hold until a read-cause is accepted.
- R11: When several fault requests arrive in one cycle, the lowest cause code is captured together with its own aux word.
- R12: A read-cause in the same cycle as a new fault request returns the old cause. The new fault is then captured, and irq stays high.
- R13: Save and restore in supervisor mode produce no fault, no read response and no irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | NSRC | One fault request strobe per external source |
| flt_code | input | 4*NSRC | Cause code per source, source 0 in the low bits |
| flt_aux | input | XLEN*NSRC | Aux word per source, source 0 in the low bits |
| tf_valid | input | 1 | Thread-fetch program counter is being used this cycle |
| tf_pc | input | XLEN | Thread-fetch program counter |
| cmd_valid | input | 1 | Host command word valid |
| cmd_word | input | 32 | Host command word |
| sup_mode | input | 1 | Host is in supervisor mode |
| launch | input | 1 | Start threads below vlen |
| vlen | input | $clog2(NTHR+1) | Current vector length |
| irq | output | 1 | Exception pending toward the host |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | XLEN | Read response data |
| priv_fault | output | 1 | Privileged command refused last cycle |
| run_flags | output | NTHR | Per-thread run flags |

## Verification
Two events can fall in the same cycle: a read-cause that acknowledges the pending exception, and a new fault request. The bench provokes this by driving the read-cause command and an external fault strobe on the same clock edge while an older exception is pending. The read is judged correct only if it returns the older cause. The new fault must then be captured: a later read-aux and read-cause return its values, and irq must not drop in between. Same-cycle requests from two sources with different codes are provoked the same way, and only the lower code and its aux may appear.

// File: rtl/vxcpt_pkg.sv
package vxcpt_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      XC_BAD_CFG     = 4'd0,
      XC_BAD_INSN    = 4'd1,
      XC_PRIV        = 4'd2,
      XC_CMD_REGIDX  = 4'd3,
      XC_TF_MISALIGN = 4'd4,
      XC_TF_FAULT    = 4'd5,
      XC_TH_BAD_INSN = 4'd6,
      XC_TH_REGIDX   = 4'd7,
      XC_LD_MISALIGN = 4'd8,
      XC_ST_MISALIGN = 4'd9,
      XC_LD_FAULT    = 4'd10,
      XC_ST_FAULT    = 4'd11
   } xcode_e;

   // command word patterns
   localparam logic [31:0] RD_MASK    = 32'hFFFF_F07F;
   localparam logic [31:0] RDC_MATCH  = 32'h0000_402B;
   localparam logic [31:0] RDA_MATCH  = 32'h0200_402B;
   localparam logic [31:0] KILL_WORD  = 32'h0400_302B;
   localparam logic [31:0] SR_MASK    = 32'hFFF0_7FFF;
   localparam logic [31:0] SAVE_MATCH = 32'h0000_302B;
   localparam logic [31:0] REST_MATCH = 32'h0200_302B;

   localparam int N_MAJOR = 4;
   localparam logic [6:0] MAJORS [N_MAJOR] = '{7'h0B, 7'h2B, 7'h5B, 7'h7B};

   function automatic logic major_ok(input logic [6:0] op);
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < N_MAJOR; i++)
         if (op == MAJORS[i]) hit = 1'b1;
      return hit;
   endfunction

endpackage

// File: rtl/vxcpt_cmd_dec.sv
module vxcpt_cmd_dec
   import vxcpt_pkg::*;
(
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_word,
   input  logic              sup_mode,
   output logic              rdc_go,
   output logic              rda_go,
   output logic              kill_go,
   output logic              flt_v,
   output logic [CODE_W-1:0] flt_code
);

   logic accepted;
   logic hit_rdc, hit_rda, hit_kill, hit_save, hit_rest, hit_priv;

   always_comb begin
      accepted = cmd_valid && major_ok(cmd_word[6:0]);
      hit_rdc  = (cmd_word & RD_MASK) == RDC_MATCH;
      hit_rda  = (cmd_word & RD_MASK) == RDA_MATCH;
      hit_kill = cmd_word == KILL_WORD;
      hit_save = (cmd_word & SR_MASK) == SAVE_MATCH;
      hit_rest = (cmd_word & SR_MASK) == REST_MATCH;
      hit_priv = hit_rdc | hit_rda | hit_kill | hit_save | hit_rest;

      rdc_go   = accepted && sup_mode && hit_rdc;
      rda_go   = accepted && sup_mode && hit_rda;
      kill_go  = accepted && sup_mode && hit_kill;
      flt_v    = accepted && (!hit_priv || !sup_mode);
      flt_code = hit_priv ? XC_PRIV : XC_BAD_INSN;
   end

endmodule

// File: rtl/vxcpt_arb.sv
module vxcpt_arb
   import vxcpt_pkg::*;
#(
   parameter int NREQ = 4,
   parameter int XLEN = 32
) (
   input  logic [NREQ-1:0]        req_v,
   input  logic [NREQ*CODE_W-1:0] req_code,
   input  logic [NREQ*XLEN-1:0]   req_aux,
   output logic                   win_v,
   output logic [CODE_W-1:0]      win_code,
   output logic [XLEN-1:0]        win_aux
);

   // lowest code wins; equal codes go to the lower request index
   always_comb begin
      win_v    = 1'b0;
      win_code = '0;
      win_aux  = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (req_v[i] && (!win_v || (req_code[i*CODE_W +: CODE_W] < win_code))) begin
            win_v    = 1'b1;
            win_code = req_code[i*CODE_W +: CODE_W];
            win_aux  = req_aux[i*XLEN +: XLEN];
         end
      end
   end

endmodule

// File: rtl/vxcpt_runflags.sv
module vxcpt_runflags #(
   parameter int NTHR = 16,
   parameter int VLW  = $clog2(NTHR + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic            kill,
   input  logic [VLW-1:0]  vlen,
   output logic [NTHR-1:0] flags
);

   logic [NTHR-1:0] below;

   for (genvar g = 0; g < NTHR; g++) begin : g_below
      assign below[g] = vlen > VLW'(g);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flags <= '0;
      else if (kill)   flags <= flags & ~below;
      else if (launch) flags <= flags | below;
   end

endmodule

// File: rtl/vxcpt_unit.sv
module vxcpt_unit
   import vxcpt_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NSRC = 4,
   parameter int NTHR = 16,
   localparam int VLW  = $clog2(NTHR + 1),
   localparam int NREQ = NSRC + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        flt_valid,
   input  logic [NSRC*CODE_W-1:0] flt_code,
   input  logic [NSRC*XLEN-1:0]   flt_aux,
   input  logic                   tf_valid,
   input  logic [XLEN-1:0]        tf_pc,
   input  logic                   cmd_valid,
   input  logic [31:0]            cmd_word,
   input  logic                   sup_mode,
   input  logic                   launch,
   input  logic [VLW-1:0]         vlen,
   output logic                   irq,
   output logic                   rd_valid,
   output logic [XLEN-1:0]        rd_data,
   output logic                   priv_fault,
   output logic [NTHR-1:0]        run_flags
);

   if (XLEN < 32) begin : g_chk_xlen
      $error("vxcpt_unit: XLEN must hold a 32-bit command word");
   end
   if (NSRC < 1) begin : g_chk_nsrc
      $error("vxcpt_unit: NSRC must be at least 1");
   end
   if (NTHR < 1) begin : g_chk_nthr
      $error("vxcpt_unit: NTHR must be at least 1");
   end

   logic                   rdc_go, rda_go, kill_go;
   logic                   cmd_flt_v;
   logic [CODE_W-1:0]      cmd_flt_code;
   logic                   tf_bad;
   logic [NREQ-1:0]        req_v;
   logic [NREQ*CODE_W-1:0] req_code;
   logic [NREQ*XLEN-1:0]   req_aux;
   logic                   win_v;
   logic [CODE_W-1:0]      win_code;
   logic [XLEN-1:0]        win_aux;
   logic                   capture;

   logic                   pend_q;
   logic [CODE_W-1:0]      cause_q;
   logic [XLEN-1:0]        aux_q;
   logic                   rd_valid_q;
   logic [XLEN-1:0]        rd_data_q;
   logic                   priv_q;

   vxcpt_cmd_dec u_dec (
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word),
      .sup_mode  (sup_mode),
      .rdc_go    (rdc_go),
      .rda_go    (rda_go),
      .kill_go   (kill_go),
      .flt_v     (cmd_flt_v),
      .flt_code  (cmd_flt_code)
   );

   assign tf_bad = tf_valid && (tf_pc[1:0] != 2'b00);

   // request 0: command decode, 1: fetch check, 2..: external sources
   assign req_v    = {flt_valid, tf_bad, cmd_flt_v};
   assign req_code = {flt_code, XC_TF_MISALIGN, cmd_flt_code};
   assign req_aux  = {flt_aux, tf_pc, XLEN'(cmd_word)};

   vxcpt_arb #(.NREQ(NREQ), .XLEN(XLEN)) u_arb (
      .req_v    (req_v),
      .req_code (req_code),
      .req_aux  (req_aux),
      .win_v    (win_v),
      .win_code (win_code),
      .win_aux  (win_aux)
   );

   // a read-cause frees the slot in the same cycle it is acknowledged
   assign capture = win_v && (!pend_q || rdc_go);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         cause_q    <= '0;
         aux_q      <= '0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         priv_q     <= 1'b0;
      end else begin
         rd_valid_q <= rdc_go || rda_go;
         if (rdc_go)      rd_data_q <= XLEN'(cause_q);
         else if (rda_go) rd_data_q <= aux_q;
         priv_q <= cmd_flt_v && (cmd_flt_code == XC_PRIV);
         if (capture) begin
            pend_q  <= 1'b1;
            cause_q <= win_code;
            aux_q   <= win_aux;
         end else if (rdc_go) begin
            pend_q  <= 1'b0;
         end
      end
   end

   vxcpt_runflags #(.NTHR(NTHR), .VLW(VLW)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .kill   (kill_go),
      .vlen   (vlen),
      .flags  (run_flags)
   );

   assign irq        = pend_q;
   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
   assign priv_fault = priv_q;

endmodule

// File: rtl/vxcpt_unit_chk.sv
module vxcpt_unit_chk #(
   parameter int XLEN = 32,
   parameter int NSRC = 4,
   parameter int NTHR = 16,
   localparam int VLW = $clog2(NTHR + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] flt_valid,
   input logic            irq,
   input logic            rd_valid,
   input logic            priv_fault,
   input logic            rdc_go,
   input logic            kill_go,
   input logic [VLW-1:0]  vlen,
   input logic [NTHR-1:0] run_flags,
   input logic [3:0]      cause_q,
   input logic [XLEN-1:0] aux_q
);

   function automatic logic [NTHR-1:0] low_mask(input logic [VLW-1:0] v);
      logic [NTHR-1:0] m;
      for (int i = 0; i < NTHR; i++) m[i] = i < int'(v);
      return m;
   endfunction

   // R2: an external fault always leaves an exception pending
   p_irq_after_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|flt_valid) |=> irq);

   // R3: an accepted read-cause is answered on the next cycle
   p_read_answered_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rdc_go |=> rd_valid);

   // R4: a refused command never yields read data and leaves irq high
   p_priv_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |-> (!rd_valid && irq));

   // R9: kill leaves no run flag set below the vector length
   p_kill_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      kill_go |=> ((run_flags & low_mask($past(vlen))) == '0));

   // R10: pending exception holds until acknowledged
   p_pending_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rdc_go) |=> irq);

   p_regs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rdc_go) |=> ($stable(cause_q) && $stable(aux_q)));

endmodule

bind vxcpt_unit vxcpt_unit_chk #(.XLEN(XLEN), .NSRC(NSRC), .NTHR(NTHR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flt_valid  (flt_valid),
   .irq        (irq),
   .rd_valid   (rd_valid),
   .priv_fault (priv_fault),
   .rdc_go     (rdc_go),
   .kill_go    (kill_go),
   .vlen       (vlen),
   .run_flags  (run_flags),
   .cause_q    (cause_q),
   .aux_q      (aux_q)
);

// File: tb/vxcpt_unit_bench.sv
module vxcpt_unit_bench;

   localparam int XLEN = 32;
   localparam int NSRC = 4;
   localparam int NTHR = 16;
   localparam int VLW  = $clog2(NTHR + 1);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NSRC-1:0]      flt_valid = '0;
   logic [NSRC*4-1:0]    flt_code = '0;
   logic [NSRC*XLEN-1:0] flt_aux = '0;
   logic                 tf_valid = 1'b0;
   logic [XLEN-1:0]      tf_pc = '0;
   logic                 cmd_valid = 1'b0;
   logic [31:0]          cmd_word = '0;
   logic                 sup_mode = 1'b1;
   logic                 launch = 1'b0;
   logic [VLW-1:0]       vlen = '0;
   logic                 irq, rd_valid, priv_fault;
   logic [XLEN-1:0]      rd_data;
   logic [NTHR-1:0]      run_flags;

   always #10 clk = ~clk;

   vxcpt_unit #(.XLEN(XLEN), .NSRC(NSRC), .NTHR(NTHR)) u_vxcpt_unit (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_code(flt_code),
      .flt_aux(flt_aux), .tf_valid(tf_valid), .tf_pc(tf_pc),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .sup_mode(sup_mode),
      .launch(launch), .vlen(vlen), .irq(irq), .rd_valid(rd_valid),
      .rd_data(rd_data), .priv_fault(priv_fault), .run_flags(run_flags)
   );

   typedef struct {
      logic [XLEN-1:0] d;
      string           tag;
   } exp_t;

   exp_t expq[$];
   int   n_chk = 0;
   int   n_bad = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: every read response must match the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R4/R5/R13 unexpected read", 64'(rd_data), 64'h0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(rd_data == e.d, e.tag, 64'(rd_data), 64'(e.d));
         end
      end
   end

   task automatic do_cmd(input logic [31:0] w, input bit sup, input bit want,
                         input logic [XLEN-1:0] ed, input string tag);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = w;
      sup_mode  = sup;
      if (want) expq.push_back('{ed, tag});
      @(negedge clk);
      cmd_valid = 1'b0;
      sup_mode  = 1'b1;
   endtask

   task automatic rd_cause(input logic [XLEN-1:0] e, input string tag);
      do_cmd(32'h0000_402B, 1'b1, 1'b1, e, tag);
   endtask

   task automatic rd_aux(input logic [XLEN-1:0] e, input string tag);
      do_cmd(32'h0200_402B, 1'b1, 1'b1, e, tag);
   endtask

   task automatic set_src(input int s, input logic [3:0] c, input logic [XLEN-1:0] a);
      flt_valid[s]          = 1'b1;
      flt_code[s*4 +: 4]    = c;
      flt_aux[s*XLEN +: XLEN] = a;
   endtask

   task automatic fault(input int s, input logic [3:0] c, input logic [XLEN-1:0] a);
      @(negedge clk);
      set_src(s, c, a);
      @(negedge clk);
      flt_valid = '0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'h0);
      chk(run_flags == '0, "R1 run flags after reset", 64'(run_flags), 64'h0);
      chk(priv_fault == 1'b0, "R1 priv_fault after reset", 64'(priv_fault), 64'h0);
      rd_aux(32'h0, "R1 aux after reset");
      rd_cause(32'h0, "R1 cause after reset");
      chk(irq == 1'b0, "R1 irq stays low", 64'(irq), 64'h0);

      // R2 / R3
      fault(1, 4'd10, 32'hDEAD_0010);
      chk(irq == 1'b1, "R2 irq after capture", 64'(irq), 64'h1);
      rd_aux(32'hDEAD_0010, "R3 read-aux data");
      chk(irq == 1'b1, "R3 read-aux keeps irq", 64'(irq), 64'h1);
      rd_cause(32'd10, "R3 read-cause data");
      chk(irq == 1'b0, "R3 read-cause clears irq", 64'(irq), 64'h0);

      // R10: second fault while pending is dropped
      fault(0, 4'd8, 32'hA000_0008);
      fault(3, 4'd3, 32'hB000_0003);
      chk(irq == 1'b1, "R10 still pending", 64'(irq), 64'h1);
      rd_aux(32'hA000_0008, "R10 aux kept");
      rd_cause(32'd8, "R10 cause kept");

      // R11: same-cycle requests, lower code wins
      @(negedge clk);
      set_src(0, 4'd11, 32'h1111_0011);
      set_src(2, 4'd9, 32'h2222_0009);
      @(negedge clk);
      flt_valid = '0;
      rd_aux(32'h2222_0009, "R11 aux of lower code");
      rd_cause(32'd9, "R11 lower code captured");

      // R8: fetch alignment
      @(negedge clk);
      tf_valid = 1'b1; tf_pc = 32'h0000_1004;
      @(negedge clk);
      tf_valid = 1'b0;
      chk(irq == 1'b0, "R8 aligned pc raises nothing", 64'(irq), 64'h0);
      @(negedge clk);
      tf_valid = 1'b1; tf_pc = 32'h0000_1002;
      @(negedge clk);
      tf_valid = 1'b0;
      chk(irq == 1'b1, "R8 misaligned pc raises", 64'(irq), 64'h1);
      rd_aux(32'h0000_1002, "R8 aux is pc");
      rd_cause(32'd4, "R8 cause 4");

      // R5: wrong major opcode ignored
      do_cmd(32'h0000_407F, 1'b1, 1'b0, '0, "");
      chk(irq == 1'b0 && rd_valid == 1'b0, "R5 major 0x7F ignored", 64'(irq), 64'h0);
      do_cmd(32'h0400_302A, 1'b1, 1'b0, '0, "");
      chk(irq == 1'b0 && rd_valid == 1'b0, "R5 major 0x2A ignored", 64'(irq), 64'h0);

      // R6: accepted but unknown
      do_cmd(32'h0000_005B, 1'b1, 1'b0, '0, "");
      chk(irq == 1'b1, "R6 unknown raises", 64'(irq), 64'h1);
      rd_aux(32'h0000_005B, "R6 aux is word");
      rd_cause(32'd1, "R6 cause 1");

      // R4: privileged read refused in user mode
      do_cmd(32'h0000_402B, 1'b0, 1'b0, '0, "");
      chk(priv_fault == 1'b1, "R4 priv_fault pulse", 64'(priv_fault), 64'h1);
      chk(irq == 1'b1, "R4 irq raised", 64'(irq), 64'h1);
      @(negedge clk);
      chk(priv_fault == 1'b0, "R4 priv_fault one cycle", 64'(priv_fault), 64'h0);
      do_cmd(32'h0200_4F2B, 1'b1, 1'b1, 32'h0000_402B, "R4 aux is word / R7 rd field free");
      rd_cause(32'd2, "R4 cause 2");

      // R9: launch and kill
      @(negedge clk);
      vlen = VLW'(5); launch = 1'b1;
      @(negedge clk);
      launch = 1'b0;
      chk(run_flags == 16'h001F, "R9 launch sets below vlen", 64'(run_flags), 64'h1F);
      do_cmd(32'h0400_302B, 1'b0, 1'b0, '0, "");
      chk(run_flags == 16'h001F, "R4 user kill has no effect", 64'(run_flags), 64'h1F);
      rd_aux(32'h0400_302B, "R4 kill word as aux");
      rd_cause(32'd2, "R4 user kill cause 2");
      @(negedge clk);
      vlen = VLW'(3);
      do_cmd(32'h0400_302B, 1'b1, 1'b0, '0, "");
      chk(run_flags == 16'h0018, "R9 kill clears below vlen", 64'(run_flags), 64'h18);
      chk(irq == 1'b0, "R9 kill raises nothing", 64'(irq), 64'h0);
      do_cmd(32'h0400_30AB, 1'b1, 1'b0, '0, "");
      chk(run_flags == 16'h0018, "R7 inexact kill is not kill", 64'(run_flags), 64'h18);
      rd_aux(32'h0400_30AB, "R7 inexact kill aux");
      rd_cause(32'd1, "R7 inexact kill cause 1");

      // R13: save and restore
      do_cmd(32'h0005_B02B, 1'b1, 1'b0, '0, "");
      chk(irq == 1'b0, "R13 save no fault", 64'(irq), 64'h0);
      do_cmd(32'h0200_302B, 1'b1, 1'b0, '0, "");
      chk(irq == 1'b0, "R13 restore no fault", 64'(irq), 64'h0);

      // R12: read-cause and new fault in the same cycle
      fault(2, 4'd10, 32'h0000_AAAA);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_word = 32'h0000_402B; sup_mode = 1'b1;
      expq.push_back('{32'd10, "R12 read returns old cause"});
      set_src(1, 4'd5, 32'h0000_5555);
      @(negedge clk);
      cmd_valid = 1'b0; flt_valid = '0;
      chk(irq == 1'b1, "R12 irq stays high", 64'(irq), 64'h1);
      rd_aux(32'h0000_5555, "R12 new aux captured");
      rd_cause(32'd5, "R12 new cause captured");
      chk(irq == 1'b0, "R12 cleared after second read", 64'(irq), 64'h0);

      repeat (2) @(negedge clk);
      chk(expq.size() == 0, "R3 all reads answered", 64'(expq.size()), 64'h0);
      summary();
      $finish;
   end

endmodule